// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block is the alert half of a temperature-sensor slave on a two-wire bus. While an interrupt event is pending it pulls an open-drain alert line. When the bus master reads from the Alert Response Address, the block acknowledges and returns its own seven-bit slave address. That address is a fixed upper nibble followed by three strap pins, and its last bit is always 0. Several slaves can share the wired-AND alert line. Each of them sends its address bit by bit on SDA and drops out when it loses arbitration. The one that completes the byte clears its pending alert.

The block sees SCL and SDA already synchronised to its clock. It also takes the strap pins, the pending-interrupt flag, the event-mode and event-polarity configuration bits, the response-enable bit, a critical-temperature flag and a pulse from the bus timeout logic. It drives only two pull-down outputs: one for SDA and one for the alert pin. Ordinary register reads and writes are handled elsewhere.

Top module: `smb_alert_responder`

## Requirements
- R1: After reset, `sda_pd_o` is 0 and, with `evt_pol_i`=0 and nothing pending, `alert_pd_o` is 0.
- R2: In interrupt mode (`int_mode_i`=1) a rising edge of `irq_pending_i` latches a pending alert. `alert_pd_o` becomes 1 within 3 clocks and stays 1 after `irq_pending_i` falls.
- R3: When an alert is pending, `ara_en_i`=1, `int_mode_i`=1 and `evt_pol_i`=0, the byte 0x19 after a START (address 0001100, read bit 1, sent MSB first) is acknowledged: SDA is pulled low for the ninth clock. With no alert pending, no acknowledge is given.
- R4: After the acknowledge the block sends the byte {0011, strap[2], strap[1], strap[0], 0} MSB first. Each bit is placed while SCL is low, and `sda_pd_o`=1 encodes a 0 bit.
- R5: After a response it completes with no arbitration loss, the pending alert is cleared and `alert_pd_o` returns to 0.
- R6: If the block leaves SDA released to send a 1 and samples SDA low at the SCL rising edge, it has lost arbitration. It drives SDA for no later bit of that byte and keeps its alert asserted.
- R7: Any first byte other than 0x19 is not acknowledged, and `sda_pd_o` stays 0 until the next START.
- R8: In comparator mode (`int_mode_i`=0) the alert follows the level of `irq_pending_i`, and the address 0x19 is not acknowledged.
- R9: With `evt_pol_i`=1 the alert output is inverted (`alert_pd_o`=1 when nothing is asserted), and the address 0x19 is not acknowledged.
- R10: While `crit_i` is 1 the alert is asserted. A response won while `crit_i` is 1 does not clear the pending alert.
- R11: With `ara_en_i`=0 the address 0x19 is not acknowledged and the alert is kept.
- R12: A STOP or a `bus_tmo_i` pulse in the middle of a transfer returns the responder to idle and leaves the pending alert unchanged. A following full alert response then works normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level |
| strap_i | input | 3 | Address strap pins, bit 2 sent first |
| irq_pending_i | input | 1 | Event condition from the sensor core |
| int_mode_i | input | 1 | 1 = interrupt mode, 0 = comparator mode |
| evt_pol_i | input | 1 | 0 = active-low alert, 1 = active-high alert |
| ara_en_i | input | 1 | Enables replies to the Alert Response Address |
| crit_i | input | 1 | Critical-temperature condition present |
| bus_tmo_i | input | 1 | One-cycle pulse from the bus timeout logic |
| sda_pd_o | output | 1 | SDA pull-down enable |
| alert_pd_o | output | 1 | Alert pin pull-down enable |

## Verification
A wrong bit counter or shift register shows up at the ports within one byte. It causes an acknowledge on the wrong clock, a returned byte that differs from the strap-derived value, or SDA held low into the master's NACK bit. A wrong arbitration state shows within the losing bit. The block either keeps driving the later bits, which the bench sees on the wired-AND line and in the drive pattern it records, or it clears an alert it did not earn, which is visible on `alert_pd_o` three clocks after the STOP. Wrong mode, polarity or critical gating is visible as a wrong alert level within three clocks of a configuration change, or as an acknowledge that should not be there.

// File: rtl/smb_alert_pkg.sv
package smb_alert_pkg;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_ADDR,
    RS_ACK,
    RS_DATA,
    RS_MACK,
    RS_WAIT
  } resp_state_e;

endpackage

// File: rtl/sab_bus_cond.sv
module sab_bus_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic bit_rise,
  output logic bit_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_comb begin
    bit_rise  = scl_i & ~scl_q;
    bit_fall  = ~scl_i & scl_q;
    bus_start = scl_i & scl_q & sda_q & ~sda_i;
    bus_stop  = scl_i & scl_q & ~sda_q & sda_i;
  end
endmodule

// File: rtl/sab_alert_ctrl.sv
module sab_alert_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic irq_pending,
  input  logic int_mode,
  input  logic evt_pol,
  input  logic ara_en,
  input  logic crit,
  input  logic win,
  output logic resp_ok,
  output logic alert_pd
);
  logic irq_q;
  logic pend;
  logic asserted;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      pend  <= 1'b0;
    end else begin
      irq_q <= irq_pending;
      if (!int_mode)
        pend <= irq_pending;
      else if (irq_pending && !irq_q)
        pend <= 1'b1;
      else if (win && !crit)
        pend <= 1'b0;
    end
  end

  always_comb begin
    asserted = pend | crit;
    resp_ok  = ara_en & int_mode & ~evt_pol & pend;
  end

  always_ff @(posedge clk) begin
    if (rst) alert_pd <= 1'b0;
    else     alert_pd <= evt_pol ? ~asserted : asserted;
  end

  AST_CLEAR_ONLY_ON_WIN: assert property (@(posedge clk) disable iff (rst)
    ($past(int_mode) && $fell(pend)) |-> $past(win)); // R5
  AST_CRIT_KEEPS_ALERT: assert property (@(posedge clk) disable iff (rst)
    $past(crit) |-> (alert_pd != $past(evt_pol))); // R10
endmodule

// File: rtl/sab_resp_fsm.sv
module sab_resp_fsm
  import smb_alert_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int STRAP_W = 3,
  parameter logic [ADDR_W-1:0] ARA_ADDR = 7'h0C,
  parameter logic [ADDR_W-STRAP_W-1:0] DEV_HI = 4'b0011
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sda_i,
  input  logic               bit_rise,
  input  logic               bit_fall,
  input  logic               bus_start,
  input  logic               bus_stop,
  input  logic               bus_tmo,
  input  logic               resp_ok,
  input  logic [STRAP_W-1:0] strap,
  output logic               sda_pd,
  output logic               win
);
  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [BYTE_W-1:0] ARA_BYTE = {ARA_ADDR, 1'b1};

  resp_state_e       state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] tx;
  logic [BYTE_W-1:0] reply;
  logic              byte_done;
  logic              seen_rise;

  assign reply = {DEV_HI, strap, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RS_IDLE;
      cnt       <= '0;
      sh        <= '0;
      tx        <= '0;
      byte_done <= 1'b0;
      seen_rise <= 1'b0;
      sda_pd    <= 1'b0;
      win       <= 1'b0;
    end else begin
      win <= 1'b0;
      if (bus_tmo || bus_stop) begin
        state  <= RS_IDLE;
        sda_pd <= 1'b0;
      end else if (bus_start) begin
        state     <= RS_ADDR;
        cnt       <= '0;
        byte_done <= 1'b0;
        seen_rise <= 1'b0;
        sda_pd    <= 1'b0;
      end else begin
        case (state)
          RS_ADDR: begin
            if (bit_rise) begin
              sh  <= {sh[BYTE_W-2:0], sda_i};
              cnt <= cnt + CNT_W'(1);
              if (cnt == LAST_BIT) byte_done <= 1'b1;
            end else if (bit_fall && byte_done) begin
              byte_done <= 1'b0;
              if (sh == ARA_BYTE && resp_ok) begin
                state  <= RS_ACK;
                sda_pd <= 1'b1;
              end else begin
                state <= RS_WAIT;
              end
            end
          end
          RS_ACK: begin
            if (bit_rise) begin
              seen_rise <= 1'b1;
            end else if (bit_fall && seen_rise) begin
              seen_rise <= 1'b0;
              state     <= RS_DATA;
              cnt       <= '0;
              tx        <= reply;
              sda_pd    <= ~reply[BYTE_W-1];
            end
          end
          RS_DATA: begin
            if (bit_rise) begin
              if (!sda_pd && !sda_i) begin
                state <= RS_WAIT;
              end else begin
                seen_rise <= 1'b1;
                cnt       <= cnt + CNT_W'(1);
                if (cnt == LAST_BIT) begin
                  byte_done <= 1'b1;
                  win       <= 1'b1;
                end
              end
            end else if (bit_fall && seen_rise) begin
              seen_rise <= 1'b0;
              if (byte_done) begin
                byte_done <= 1'b0;
                state     <= RS_MACK;
                sda_pd    <= 1'b0;
              end else begin
                tx     <= tx << 1;
                sda_pd <= ~tx[BYTE_W-2];
              end
            end
          end
          RS_MACK: begin
            if (bit_rise) state <= RS_WAIT;
          end
          default: ;
        endcase
      end
    end
  end

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst)
    bus_stop |=> !sda_pd); // R12
  AST_ACK_NEEDS_OK: assert property (@(posedge clk) disable iff (rst)
    (state == RS_ACK && $past(state) == RS_ADDR) |-> $past(resp_ok)); // R11
  AST_LOSS_STOPS: assert property (@(posedge clk) disable iff (rst)
    (state == RS_DATA && bit_rise && !sda_pd && !sda_i && !bus_tmo)
      |=> (state == RS_WAIT && !win && !sda_pd)); // R6
endmodule

// File: rtl/smb_alert_responder.sv
module smb_alert_responder #(
  parameter int ADDR_W  = 7,
  parameter int STRAP_W = 3,
  parameter logic [ADDR_W-1:0] ARA_ADDR = 7'h0C,
  parameter logic [ADDR_W-STRAP_W-1:0] DEV_HI = 4'b0011
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic               irq_pending_i,
  input  logic               int_mode_i,
  input  logic               evt_pol_i,
  input  logic               ara_en_i,
  input  logic               crit_i,
  input  logic               bus_tmo_i,
  output logic               sda_pd_o,
  output logic               alert_pd_o
);
  logic bit_rise, bit_fall, bus_start, bus_stop;
  logic resp_ok, win;

  sab_bus_cond u_cond (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .bit_rise(bit_rise), .bit_fall(bit_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  sab_resp_fsm #(
    .ADDR_W(ADDR_W), .STRAP_W(STRAP_W), .ARA_ADDR(ARA_ADDR), .DEV_HI(DEV_HI)
  ) u_fsm (
    .clk(clk), .rst(rst), .sda_i(sda_i),
    .bit_rise(bit_rise), .bit_fall(bit_fall),
    .bus_start(bus_start), .bus_stop(bus_stop), .bus_tmo(bus_tmo_i),
    .resp_ok(resp_ok), .strap(strap_i),
    .sda_pd(sda_pd_o), .win(win)
  );

  sab_alert_ctrl u_alert (
    .clk(clk), .rst(rst), .irq_pending(irq_pending_i),
    .int_mode(int_mode_i), .evt_pol(evt_pol_i), .ara_en(ara_en_i),
    .crit(crit_i), .win(win), .resp_ok(resp_ok), .alert_pd(alert_pd_o)
  );

  AST_DRIVE_WHILE_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pd_o) |-> !$past(scl_i)); // R4
endmodule

// File: tb/smb_alert_responder_bench.sv
module smb_alert_responder_bench;
  localparam int CLK_P = 10;
  localparam int Q     = 6;

  logic clk = 0, rst = 1;
  logic scl = 1, sda_m = 1, other_pd = 0;
  logic [2:0] strap = 3'b101;
  logic irq = 0, int_mode = 1, evt_pol = 0, ara_en = 1, crit = 0, tmo = 0;
  logic sda_pd, alert_pd;
  logic sda_line;
  int checks = 0, errors = 0, drv_cycles = 0;

  assign sda_line = sda_m & ~sda_pd & ~other_pd;

  always #(CLK_P/2) clk = ~clk;

  smb_alert_responder u_smb_alert_responder (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .strap_i(strap),
    .irq_pending_i(irq), .int_mode_i(int_mode), .evt_pol_i(evt_pol),
    .ara_en_i(ara_en), .crit_i(crit), .bus_tmo_i(tmo),
    .sda_pd_o(sda_pd), .alert_pd_o(alert_pd)
  );

  always @(negedge clk) if (sda_pd) drv_cycles++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic m_start();
    sda_m = 1; scl = 1; tick(Q);
    sda_m = 0; tick(Q);
    scl = 0;
  endtask

  task automatic m_stop();
    sda_m = 0; tick(Q);
    scl = 1; tick(Q);
    sda_m = 1; tick(Q);
  endtask

  task automatic m_bit_w(input logic b);
    sda_m = b; tick(Q);
    scl = 1; tick(Q);
    scl = 0;
  endtask

  task automatic m_bit_r(output logic v, output logic d);
    sda_m = 1; tick(Q);
    scl = 1; tick(Q/2);
    v = sda_line; d = sda_pd;
    tick(Q - Q/2);
    scl = 0;
  endtask

  task automatic do_ara(input logic [7:0] first, input logic other_on,
                        input logic [7:0] other_byte, output logic acked,
                        output logic [7:0] rd, output logic [7:0] drv);
    logic v, d, alive;
    rd = 8'h00; drv = 8'h00; alive = other_on;
    m_start();
    for (int i = 7; i >= 0; i--) m_bit_w(first[i]);
    other_pd = other_on;
    m_bit_r(v, d);
    acked = d;
    if (!v) begin
      for (int i = 7; i >= 0; i--) begin
        other_pd = alive & ~other_byte[i];
        m_bit_r(v, d);
        rd[i] = v; drv[i] = d;
        if (alive && other_byte[i] && !v) alive = 0;
      end
      other_pd = 0;
      m_bit_w(1'b1);
    end
    other_pd = 0;
    m_stop();
  endtask

  task automatic raise_irq();
    irq = 1; tick(2); irq = 0; tick(3);
  endtask

  task automatic t_reset();
    check("R1 sda_pd after reset", sda_pd, 0);
    check("R1 alert_pd after reset", alert_pd, 0);
  endtask

  task automatic t_alert_set();
    raise_irq();
    check("R2 alert latched", alert_pd, 1);
  endtask

  task automatic t_ara_win();
    logic a; logic [7:0] rd, drv;
    do_ara(8'h19, 0, 8'h00, a, rd, drv);
    check("R3 ack of 0x19", a, 1);
    check("R4 returned byte", rd, 8'h3A);
    check("R4 drive pattern", drv, 8'hC5);
    tick(3);
    check("R5 alert cleared after win", alert_pd, 0);
    do_ara(8'h19, 0, 8'h00, a, rd, drv);
    check("R3 no ack without pending alert", a, 0);
  endtask

  task automatic t_other_addr();
    logic a; logic [7:0] rd, drv;
    raise_irq();
    drv_cycles = 0;
    do_ara(8'h91, 0, 8'h00, a, rd, drv);
    check("R7 no drive on other address", drv_cycles, 0);
    check("R7 alert kept", alert_pd, 1);
  endtask

  task automatic t_loss();
    logic a; logic [7:0] rd, drv;
    do_ara(8'h19, 1, 8'h32, a, rd, drv);
    check("R6 line carries winner byte", rd, 8'h32);
    check("R6 no drive after loss", drv, 8'hC0);
    tick(3);
    check("R6 alert kept after loss", alert_pd, 1);
    do_ara(8'h19, 0, 8'h00, a, rd, drv);
    tick(3);
    check("R6 later solo response clears", alert_pd, 0);
  endtask

  task automatic t_ara_disabled();
    logic a; logic [7:0] rd, drv;
    ara_en = 0; raise_irq();
    do_ara(8'h19, 0, 8'h00, a, rd, drv);
    check("R11 no ack when disabled", a, 0);
    check("R11 alert kept", alert_pd, 1);
    ara_en = 1;
    do_ara(8'h19, 0, 8'h00, a, rd, drv);
    tick(3);
    check("R11 clears once enabled", alert_pd, 0);
  endtask

  task automatic t_abort();
    logic a; logic [7:0] rd, drv;
    raise_irq();
    drv_cycles = 0;
    m_start();
    for (int i = 7; i >= 5; i--) m_bit_w(1'(8'h19 >> i));
    m_stop();
    tick(3);
    check("R12 alert kept after STOP", alert_pd, 1);
    m_start();
    for (int i = 7; i >= 3; i--) m_bit_w(1'(8'h19 >> i));
    tmo = 1; tick(1); tmo = 0; tick(3);
    check("R12 alert kept after timeout", alert_pd, 1);
    check("R12 no drive while aborted", drv_cycles, 0);
    do_ara(8'h19, 0, 8'h00, a, rd, drv);
    check("R12 response after abort", rd, 8'h3A);
    tick(3);
    check("R12 cleared after abort recovery", alert_pd, 0);
  endtask

  task automatic t_crit();
    logic a; logic [7:0] rd, drv;
    crit = 1; tick(3);
    check("R10 crit asserts alert", alert_pd, 1);
    raise_irq();
    do_ara(8'h19, 0, 8'h00, a, rd, drv);
    check("R10 ack while crit", a, 1);
    tick(3);
    check("R10 alert held by crit", alert_pd, 1);
    crit = 0; tick(3);
    check("R10 pending kept after crit win", alert_pd, 1);
    do_ara(8'h19, 0, 8'h00, a, rd, drv);
    tick(3);
    check("R10 cleared without crit", alert_pd, 0);
  endtask

  task automatic t_comparator();
    logic a; logic [7:0] rd, drv;
    int_mode = 0; irq = 1; tick(3);
    check("R8 comparator alert on", alert_pd, 1);
    do_ara(8'h19, 0, 8'h00, a, rd, drv);
    check("R8 no ack in comparator", a, 0);
    irq = 0; tick(3);
    check("R8 comparator alert off", alert_pd, 0);
    int_mode = 1; tick(2);
  endtask

  task automatic t_polarity();
    logic a; logic [7:0] rd, drv;
    evt_pol = 1; tick(3);
    check("R9 inverted idle", alert_pd, 1);
    raise_irq();
    check("R9 inverted asserted", alert_pd, 0);
    do_ara(8'h19, 0, 8'h00, a, rd, drv);
    check("R9 no ack with polarity 1", a, 0);
    evt_pol = 0; tick(3);
    check("R9 pending kept", alert_pd, 1);
    do_ara(8'h19, 0, 8'h00, a, rd, drv);
    tick(3);
    check("R9 cleared after restore", alert_pd, 0);
  endtask

  initial begin
    tick(4); rst = 0; tick(3);
    t_reset();
    t_alert_set();
    t_ara_win();
    t_other_addr();
    t_loss();
    t_ara_disabled();
    t_abort();
    t_crit();
    t_comparator();
    t_polarity();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R0 watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule